// File: doc/BRIEF.md
# Load/Store Exception Priority Selector

This block decides which one exception a load, store or cache-management instruction takes when it raises several exception conditions in the same cycle. Fetch, decode, translation, alignment and debug logic each present a request flag. The selector qualifies those flags against the instruction class (integer or floating-point) and against the machine-state bits for problem state and floating-point enable. It derives the floating-point program and unavailable causes from three status inputs: whether a floating-point unit is present, whether that unit recognizes the instruction, and whether it supports it. It then picks the highest-ranked surviving cause.

The result is registered. One cycle after an instruction is presented, the block drives a one-cycle valid pulse, a one-hot cause vector and a 4-bit code. The code is the rank of the winning cause within the order of its class, with 1 for the highest rank. Vector generation, pipeline flush and save/restore of machine state belong to the neighbouring logic.

The design has no sequencing of its own: a qualify stage and a pick stage are purely combinational, and one register stage follows them. It therefore has no named states or transitions.

Top module: `lsx_prio_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it has been sampled high, `exc_valid`, `exc_cause` and `exc_code` are all zero.
- R2: For a floating-point instruction, the order from highest to lowest is: instruction-address compare (code 1), instruction TLB miss (2), instruction protection (3), illegal (4), floating-point unavailable (5), unimplemented (6), data TLB miss (7), data storage (8), alignment (9), data compare (10), instruction complete (11).
- R3: For an integer instruction, the order from highest to lowest is: instruction-address compare (1), instruction TLB miss (2), instruction protection (3), illegal (4), privileged (5), data TLB miss (6), data storage (7), alignment (8), data compare (9), instruction complete (10). The floating-point unavailable and unimplemented causes never win for this class.
- R4: For a floating-point instruction, the illegal cause is raised when `fpu_present` is 0, or when `fpu_recog` is 0.
- R5: For a floating-point instruction, the unavailable cause is raised when the unit is present and recognizes the instruction but `msr_fp` is 0.
- R6: For a floating-point instruction, the unimplemented cause is raised when the unit is present, recognizes the instruction, does not support it (`fpu_supp`=0), and `msr_fp` is 1. At most one of R4, R5 and R6 holds at a time. A present unit that recognizes and supports the instruction with `msr_fp`=1 raises none of them.
- R7: For an integer instruction, the privileged cause is raised only when `is_cache_inval` is 1 and `msr_pr` is 1. It is never raised for a floating-point instruction.
- R8: For an integer instruction, the illegal cause is raised when `is_dword` is 1. The inputs `fpu_present`, `fpu_recog`, `fpu_supp` and `msr_fp` have no effect on the integer class.
- R9: A data-storage request is dropped when `dstor_byteord` is 1 and the class is integer, or when `dstor_lock` is 1 and the class is floating-point. In any other case it stands.
- R10: Outputs are registered. Requests presented with `op_valid`=1 in cycle N appear in cycle N+1. `exc_valid` is 1 for exactly the cycles after an instruction that had at least one qualified request. When `op_valid` is 0, no request counts. `exc_code` is 0 whenever `exc_valid` is 0.
- R11: `exc_cause` has at most one bit set, and that bit is set exactly when `exc_valid` is 1. The bit positions are: 0 instruction-address compare, 1 instruction TLB miss, 2 instruction protection, 3 illegal, 4 privileged, 5 unavailable, 6 unimplemented, 7 data TLB miss, 8 data storage, 9 alignment, 10 data compare, 11 instruction complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An instruction is presented this cycle |
| is_fp | input | 1 | 1 = floating-point load/store, 0 = integer class |
| is_cache_inval | input | 1 | Instruction is the data-cache invalidate operation |
| is_dword | input | 1 | Instruction is a 64-bit load/store/cache operation that the core does not recognize |
| msr_pr | input | 1 | Problem-state bit |
| msr_fp | input | 1 | Floating-point enable bit |
| fpu_present | input | 1 | A floating-point unit is attached |
| fpu_recog | input | 1 | The unit recognizes the instruction |
| fpu_supp | input | 1 | The unit supports the instruction |
| iac_hit | input | 1 | Debug instruction-address compare |
| itlb_miss | input | 1 | Instruction TLB miss |
| ifetch_prot | input | 1 | Instruction execute-access violation |
| dtlb_miss | input | 1 | Data TLB miss |
| dstor_req | input | 1 | Data-storage request |
| dstor_byteord | input | 1 | The data-storage request is of the byte-ordering kind |
| dstor_lock | input | 1 | The data-storage request is of the cache-locking kind |
| align_req | input | 1 | Alignment fault |
| dcmp_hit | input | 1 | Debug data-address or data-value compare |
| icomp_hit | input | 1 | Debug instruction-complete |
| exc_valid | output | 1 | One-cycle pulse: an exception was selected |
| exc_cause | output | 12 | One-hot winning cause (positions in R11) |
| exc_code | output | 4 | Rank of the winner within its class, 0 if none |

## Verification
The riskiest overlaps are a derived program cause and a data-storage request that arrive together with its class-specific drop condition set. For example, a floating-point instruction can have no unit attached while it also carries a cache-locking data-storage request. The bench provokes these overlaps with ladders that start from every request asserted and remove the current winner one step at a time. It judges each step against hand-derived bit positions and codes. A random sweep over both classes then compares every cycle against a reference model that walks an explicit order list for each class.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
    localparam int NCAUSE = 12;
    localparam int CODE_W = 4;

    // global cause positions; ascending position = descending priority
    localparam int P_IAC    = 0;
    localparam int P_ITLB   = 1;
    localparam int P_IPROT  = 2;
    localparam int P_ILL    = 3;
    localparam int P_PRIV   = 4;
    localparam int P_UNAV   = 5;
    localparam int P_UNIMP  = 6;
    localparam int P_DTLB   = 7;
    localparam int P_DSTOR  = 8;
    localparam int P_ALIGN  = 9;
    localparam int P_DCMP   = 10;
    localparam int P_ICOMP  = 11;

    // does a cause position belong to the order of a class
    function automatic logic in_class(input logic fp, input int pos);
        if (fp) return (pos != P_PRIV);
        return (pos != P_UNAV) && (pos != P_UNIMP);
    endfunction

    // rank of a position within its class order, 1 = highest
    function automatic logic [CODE_W-1:0] class_rank(input logic fp, input int pos);
        int r;
        r = 0;
        for (int k = 0; k <= pos; k++)
            if (in_class(fp, k)) r++;
        return CODE_W'(r);
    endfunction
endpackage

// File: rtl/lsx_qualify.sv
module lsx_qualify
    import lsx_pkg::*;
#(
    parameter int NC = NCAUSE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic          is_fp,
    input  logic          is_cache_inval,
    input  logic          is_dword,
    input  logic          msr_pr,
    input  logic          msr_fp,
    input  logic          fpu_present,
    input  logic          fpu_recog,
    input  logic          fpu_supp,
    input  logic          iac_hit,
    input  logic          itlb_miss,
    input  logic          ifetch_prot,
    input  logic          dtlb_miss,
    input  logic          dstor_req,
    input  logic          dstor_byteord,
    input  logic          dstor_lock,
    input  logic          align_req,
    input  logic          dcmp_hit,
    input  logic          icomp_hit,
    output logic [NC-1:0] qual
);
    logic fpu_knows;
    logic dstor_keep;

    always_comb begin
        fpu_knows  = fpu_present & fpu_recog;
        dstor_keep = dstor_req & (is_fp ? ~dstor_lock : ~dstor_byteord);
        qual = '0;
        if (op_valid) begin
            qual[P_IAC]   = iac_hit;
            qual[P_ITLB]  = itlb_miss;
            qual[P_IPROT] = ifetch_prot;
            if (is_fp) begin
                qual[P_ILL]   = ~fpu_knows;
                qual[P_UNAV]  = fpu_knows & ~msr_fp;
                qual[P_UNIMP] = fpu_knows & ~fpu_supp & msr_fp;
            end else begin
                qual[P_ILL]   = is_dword;
                qual[P_PRIV]  = is_cache_inval & msr_pr;
            end
            qual[P_DTLB]  = dtlb_miss;
            qual[P_DSTOR] = dstor_keep;
            qual[P_ALIGN] = align_req;
            qual[P_DCMP]  = dcmp_hit;
            qual[P_ICOMP] = icomp_hit;
        end
    end

    // R6
    fp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_fp) |-> $onehot0({qual[P_ILL], qual[P_UNAV], qual[P_UNIMP]}));

    // R7
    fp_no_priv_chk: assert property (@(posedge clk) disable iff (rst)
        is_fp |-> !qual[P_PRIV]);
endmodule

// File: rtl/lsx_pick.sv
module lsx_pick
    import lsx_pkg::*;
#(
    parameter int NC = NCAUSE,
    parameter int CW = CODE_W
) (
    input  logic          is_fp,
    input  logic [NC-1:0] qual,
    output logic [NC-1:0] win,
    output logic [CW-1:0] code,
    output logic          any
);
    logic [CW-1:0] rank_int [NC];
    logic [CW-1:0] rank_fp  [NC];

    for (genvar g = 0; g < NC; g++) begin : g_rank
        assign rank_int[g] = CW'(class_rank(1'b0, g));
        assign rank_fp[g]  = CW'(class_rank(1'b1, g));
    end

    always_comb begin
        win  = qual & (~qual + NC'(1));
        any  = |qual;
        code = '0;
        for (int i = 0; i < NC; i++)
            if (win[i]) code = is_fp ? rank_fp[i] : rank_int[i];
    end
endmodule

// File: rtl/lsx_prio_sel.sv
module lsx_prio_sel
    import lsx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              is_fp,
    input  logic              is_cache_inval,
    input  logic              is_dword,
    input  logic              msr_pr,
    input  logic              msr_fp,
    input  logic              fpu_present,
    input  logic              fpu_recog,
    input  logic              fpu_supp,
    input  logic              iac_hit,
    input  logic              itlb_miss,
    input  logic              ifetch_prot,
    input  logic              dtlb_miss,
    input  logic              dstor_req,
    input  logic              dstor_byteord,
    input  logic              dstor_lock,
    input  logic              align_req,
    input  logic              dcmp_hit,
    input  logic              icomp_hit,
    output logic              exc_valid,
    output logic [NCAUSE-1:0] exc_cause,
    output logic [CODE_W-1:0] exc_code
);
    logic [NCAUSE-1:0] qual;
    logic [NCAUSE-1:0] win;
    logic [CODE_W-1:0] code;
    logic              any;

    lsx_qualify #(.NC(NCAUSE)) u_qual (
        .clk(clk), .rst(rst), .op_valid(op_valid), .is_fp(is_fp),
        .is_cache_inval(is_cache_inval), .is_dword(is_dword),
        .msr_pr(msr_pr), .msr_fp(msr_fp), .fpu_present(fpu_present),
        .fpu_recog(fpu_recog), .fpu_supp(fpu_supp), .iac_hit(iac_hit),
        .itlb_miss(itlb_miss), .ifetch_prot(ifetch_prot),
        .dtlb_miss(dtlb_miss), .dstor_req(dstor_req),
        .dstor_byteord(dstor_byteord), .dstor_lock(dstor_lock),
        .align_req(align_req), .dcmp_hit(dcmp_hit), .icomp_hit(icomp_hit),
        .qual(qual)
    );

    lsx_pick #(.NC(NCAUSE), .CW(CODE_W)) u_pick (
        .is_fp(is_fp), .qual(qual), .win(win), .code(code), .any(any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid <= 1'b0;
            exc_cause <= '0;
            exc_code  <= '0;
        end else begin
            exc_valid <= any;
            exc_cause <= win;
            exc_code  <= code;
        end
    end

    // R11
    cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(exc_cause));

    // R11
    cause_valid_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid == (exc_cause != '0));

    // R10
    code_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> (exc_code == '0));

    // R10
    valid_source_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> $past(op_valid));

    // R3
    class_cause_chk: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ($past(is_fp) ? !exc_cause[P_PRIV]
                                    : !(exc_cause[P_UNAV] || exc_cause[P_UNIMP])));
endmodule

// File: tb/lsx_prio_sel_test.sv
module lsx_prio_sel_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid, is_fp, is_cache_inval, is_dword, msr_pr, msr_fp;
    logic fpu_present, fpu_recog, fpu_supp;
    logic iac_hit, itlb_miss, ifetch_prot, dtlb_miss, dstor_req;
    logic dstor_byteord, dstor_lock, align_req, dcmp_hit, icomp_hit;
    logic        exc_valid;
    logic [11:0] exc_cause;
    logic [3:0]  exc_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsx_prio_sel uut (.*);

    task automatic clr_all();
        {op_valid, is_fp, is_cache_inval, is_dword, msr_pr, msr_fp} = '0;
        {fpu_present, fpu_recog, fpu_supp} = '0;
        {iac_hit, itlb_miss, ifetch_prot, dtlb_miss, dstor_req} = '0;
        {dstor_byteord, dstor_lock, align_req, dcmp_hit, icomp_hit} = '0;
    endtask

    // after an edge, sample away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic ev,
                         input logic [11:0] ec, input logic [3:0] ek);
        checks++;
        if (exc_valid !== ev || exc_cause !== ec || exc_code !== ek) begin
            errors++;
            $display("FAIL %s: got v=%0b cause=%03h code=%0d exp v=%0b cause=%03h code=%0d",
                     req, exc_valid, exc_cause, exc_code, ev, ec, ek);
        end
    endtask

    function automatic logic [11:0] bitv(input int p);
        return 12'(1) << p;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        clr_all();
        op_valid = 1; iac_hit = 1;
        tick();
        check("R1", 0, 12'h0, 0);
        tick();
        check("R1", 0, 12'h0, 0);
        rst = 1'b0;
        clr_all();
        tick();
    endtask

    // every FP cause present, peel off winner each step
    task automatic t_fp_ladder();
        clr_all();
        op_valid = 1; is_fp = 1;
        iac_hit = 1; itlb_miss = 1; ifetch_prot = 1; dtlb_miss = 1;
        dstor_req = 1; align_req = 1; dcmp_hit = 1; icomp_hit = 1;
        is_cache_inval = 1; msr_pr = 1;   // must not make privileged (R7)
        tick(); check("R2 iac", 1, bitv(0), 1);
        iac_hit = 0;     tick(); check("R2 itlb", 1, bitv(1), 2);
        itlb_miss = 0;   tick(); check("R2 iprot", 1, bitv(2), 3);
        ifetch_prot = 0; tick(); check("R4 no unit", 1, bitv(3), 4);
        fpu_present = 1; tick(); check("R4 unrecognized", 1, bitv(3), 4);
        fpu_recog = 1;   tick(); check("R5 unavailable", 1, bitv(5), 5);
        msr_fp = 1;      tick(); check("R6 unimplemented", 1, bitv(6), 6);
        fpu_supp = 1;    tick(); check("R2 dtlb", 1, bitv(7), 7);
        dtlb_miss = 0;   tick(); check("R2 dstor", 1, bitv(8), 8);
        dstor_req = 0;   tick(); check("R2 align", 1, bitv(9), 9);
        align_req = 0;   tick(); check("R2 dcmp", 1, bitv(10), 10);
        dcmp_hit = 0;    tick(); check("R2 icomp", 1, bitv(11), 11);
        icomp_hit = 0;   tick(); check("R6 clean fp", 0, 12'h0, 0);
    endtask

    task automatic t_int_ladder();
        clr_all();
        op_valid = 1; is_fp = 0;
        iac_hit = 1; itlb_miss = 1; ifetch_prot = 1; is_dword = 1;
        is_cache_inval = 1; msr_pr = 1; dtlb_miss = 1; dstor_req = 1;
        align_req = 1; dcmp_hit = 1; icomp_hit = 1;
        // FP status set to values that would raise FP causes (R8)
        fpu_present = 1; fpu_recog = 1; msr_fp = 0;
        tick(); check("R3 iac", 1, bitv(0), 1);
        iac_hit = 0;     tick(); check("R3 itlb", 1, bitv(1), 2);
        itlb_miss = 0;   tick(); check("R3 iprot", 1, bitv(2), 3);
        ifetch_prot = 0; tick(); check("R8 dword illegal", 1, bitv(3), 4);
        is_dword = 0;    tick(); check("R7 privileged", 1, bitv(4), 5);
        msr_pr = 0;      tick(); check("R7 supervisor", 1, bitv(7), 6);
        dtlb_miss = 0;   tick(); check("R3 dstor", 1, bitv(8), 7);
        dstor_req = 0;   tick(); check("R3 align", 1, bitv(9), 8);
        align_req = 0;   tick(); check("R3 dcmp", 1, bitv(10), 9);
        dcmp_hit = 0;    tick(); check("R3 icomp", 1, bitv(11), 10);
        icomp_hit = 0;   tick(); check("R8 fp status ignored", 0, 12'h0, 0);
        fpu_present = 0; msr_fp = 1; tick(); check("R8 no unit ignored", 0, 12'h0, 0);
    endtask

    task automatic t_dstor_filter();
        clr_all();
        op_valid = 1; dstor_req = 1; dstor_byteord = 1;
        tick(); check("R9 int byteord drop", 0, 12'h0, 0);
        dstor_byteord = 0; dstor_lock = 1;
        tick(); check("R9 int lock kept", 1, bitv(8), 7);
        is_fp = 1; fpu_present = 1; fpu_recog = 1; fpu_supp = 1; msr_fp = 1;
        tick(); check("R9 fp lock drop", 0, 12'h0, 0);
        dstor_lock = 0; dstor_byteord = 1;
        tick(); check("R9 fp byteord kept", 1, bitv(8), 8);
        // overlap: derived illegal and dropped storage request
        dstor_lock = 1; fpu_present = 0;
        tick(); check("R9 R4 overlap", 1, bitv(3), 4);
    endtask

    task automatic t_timing();
        clr_all();
        op_valid = 0; iac_hit = 1; is_fp = 1;
        tick(); check("R10 op_valid low", 0, 12'h0, 0);
        op_valid = 1; is_fp = 0; align_req = 1; iac_hit = 0;
        @(posedge clk); #1;
        check("R10 pulse", 1, bitv(9), 8);
        clr_all();
        tick(); check("R10 pulse ends", 0, 12'h0, 0);
    endtask

    function automatic void ref_eval(output logic v, output logic [11:0] c,
                                     output logic [3:0] k);
        int fp_ord [11] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 10, 11};
        int in_ord [10] = '{0, 1, 2, 3, 4, 7, 8, 9, 10, 11};
        logic [11:0] r;
        r = '0;
        v = 0; c = '0; k = '0;
        if (!op_valid) return;
        r[0] = iac_hit; r[1] = itlb_miss; r[2] = ifetch_prot;
        r[7] = dtlb_miss; r[9] = align_req; r[10] = dcmp_hit; r[11] = icomp_hit;
        if (is_fp) begin
            r[3] = !(fpu_present && fpu_recog);
            r[5] = fpu_present && fpu_recog && !msr_fp;
            r[6] = fpu_present && fpu_recog && !fpu_supp && msr_fp;
            r[8] = dstor_req && !dstor_lock;
            for (int i = 0; i < 11; i++)
                if (!v && r[fp_ord[i]]) begin
                    v = 1; c = bitv(fp_ord[i]); k = 4'(i + 1);
                end
        end else begin
            r[3] = is_dword;
            r[4] = is_cache_inval && msr_pr;
            r[8] = dstor_req && !dstor_byteord;
            for (int i = 0; i < 10; i++)
                if (!v && r[in_ord[i]]) begin
                    v = 1; c = bitv(in_ord[i]); k = 4'(i + 1);
                end
        end
    endfunction

    task automatic t_random();
        logic ev;
        logic [11:0] ec;
        logic [3:0] ek;
        for (int n = 0; n < 3000; n++) begin
            logic [20:0] r;
            r = 21'($urandom);
            {is_fp, is_cache_inval, is_dword, msr_pr, msr_fp,
             fpu_present, fpu_recog, fpu_supp} = r[7:0];
            op_valid = (r[20:18] != 0);
            // sparse requests so lower ranks also win
            iac_hit = ($urandom_range(7) == 0); itlb_miss = ($urandom_range(7) == 0);
            ifetch_prot = ($urandom_range(7) == 0); dtlb_miss = ($urandom_range(5) == 0);
            dstor_req = r[8]; dstor_byteord = r[9]; dstor_lock = r[10];
            align_req = r[11] & r[12]; dcmp_hit = r[13] & r[14]; icomp_hit = r[15];
            ref_eval(ev, ec, ek);
            tick();
            check("R11 random vs reference", ev, ec, ek);
        end
        clr_all();
        tick();
    endtask

    initial begin
        clr_all();
        t_reset();
        t_fp_ladder();
        t_int_ladder();
        t_dstor_filter();
        t_timing();
        t_random();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule